// File: doc/BRIEF.md
# Snapshot-Latched Wide Timer Reader

This block keeps a free-running tick counter in a timer clock domain and lets a host with a narrower data bus read it without ever seeing a torn value. The counter is 32 bits wide and the host bus is 16 bits, so a full reading takes two bus accesses. Reading the live counter twice would let a carry ripple between the two halves. Instead, the whole counter is copied into a snapshot register in a single timer cycle, and both halves are read from that frozen copy.

The host clock and the timer clock are unrelated. To take a reading, the host raises a hold request and keeps it high. The request crosses into the timer domain through a two-flop synchronizer, and the capture fires on the rising edge of the synchronized request. An acknowledge then crosses back through two host-domain flops and appears as a capture-done flag. The host polls that flag, reads the two halves in any order and as often as it likes, and then drops the request. A new request can only start once the done flag has returned low, which makes the exchange a four-phase handshake.

Top module: `snap_timer_reader`

## Requirements
- R1: The counter advances by exactly one on every timer clock after reset. It wraps from all ones to zero.
- R2: While reset is low, the counter, the snapshot and the capture-done flag are cleared. After reset, both read addresses return zero and cap_done is low.
- R3: The request reaches the capture logic through two timer-domain flops. The captured value is therefore at least 2 counts above the count at the moment hold_req rose, and no later than the count at the moment cap_done is seen high.
- R4: A capture copies all counter bits in one timer cycle. The word assembled from both read halves equals one single count value.
- R5: The snapshot does not change between captures, however long the host waits before or between reads.
- R6: cap_done rises only after the capture has been made, and stays high while hold_req stays high. It falls again after hold_req is lowered.
- R7: A request held high produces one capture only. A request raised again while cap_done is still high is deferred: cap_done must first fall, and only then does a new capture occur.
- R8: rd_addr = 0 returns snapshot bits [BUS_W-1:0] and rd_addr = 1 returns bits [2*BUS_W-1:BUS_W]. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tmr_clk | input | 1 | Timer clock; the counter advances on each rising edge |
| tmr_rst_n | input | 1 | Synchronous active-low reset for the timer domain |
| host_clk | input | 1 | Host clock |
| host_rst_n | input | 1 | Synchronous active-low reset for the host domain |
| hold_req | input | 1 | Host request to capture the counter; held high until cap_done is seen |
| cap_done | output | 1 | Capture-done flag, synchronized into the host domain |
| rd_addr | input | ADDR_W (1) | Selects which half of the snapshot is read |
| rd_data | output | BUS_W (16) | Selected snapshot half |

## Verification
The hardest situation to reach is a capture that lands exactly as the counter wraps, where the two halves would disagree if the copy were split. The bench runs the block with a 12-bit counter and a 6-bit bus. A sweep of several hundred back-to-back captures, with varying idle gaps, drifts the request phase across the unrelated timer clock and passes through the wrap several times. Each assembled snapshot is checked against a modular window computed from a bench-side tick count. The second hard case is a request dropped and raised again while the done flag is still high. The bench forces it with a one-cycle dip in the request, and then requires cap_done to fall before a fresh capture appears.

// File: rtl/snap_pkg.sv
// Package: default sizes shared by the snapshot timer reader and its users.
// Assumes the counter width is a whole multiple of the bus width.
package snap_pkg;
    localparam int DEF_CNT_W  = 32;
    localparam int DEF_BUS_W  = 16;
    localparam int DEF_SYNC_N = 2;

    // Number of bus words needed to cover the counter.
    function automatic int word_count(input int cnt_w, input int bus_w);
        return (cnt_w + bus_w - 1) / bus_w;
    endfunction

    // Address width for a given word count; at least one bit.
    function automatic int addr_width(input int words);
        return (words > 1) ? $clog2(words) : 1;
    endfunction
endpackage

// File: rtl/snap_sync.sv
// Module: multi-flop level synchronizer.
// Brings a single level signal into the clk domain through STAGES flops.
// Assumes the input is a level that stays put long enough to be seen.
module snap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/snap_counter.sv
// Module: free-running tick counter in the timer domain.
// Adds one per timer clock and wraps naturally at all ones.
module snap_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Advance the tick count; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + ONE;
    end
endmodule

// File: rtl/snap_capture.sv
// Module: timer-domain capture unit.
// Synchronizes the host request, fires a one-cycle capture on its rising
// edge, copies the full counter into the snapshot and raises an acknowledge
// that tracks the synchronized request.
// Assumes the request is held until the acknowledge has been seen.
module snap_capture #(
    parameter int CNT_W  = 32,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_async,
    input  logic [CNT_W-1:0] count,
    output logic             cap_fire,
    output logic             ack,
    output logic [CNT_W-1:0] snapshot
);
    logic req_t;

    snap_sync #(.STAGES(SYNC_N)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_async),
        .q     (req_t)
    );

    // Rising edge of the synchronized request, seen against the acknowledge.
    assign cap_fire = req_t & ~ack;

    // Acknowledge follows the synchronized request one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) ack <= 1'b0;
        else        ack <= req_t;
    end

    // Copy the whole counter in one cycle on a capture; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        snapshot <= '0;
        else if (cap_fire) snapshot <= count;
    end
endmodule

// File: rtl/snap_host_side.sv
// Module: host-domain handshake gate.
// Forwards the host request to the timer domain and synchronizes the
// acknowledge back as the done flag. A request may only start while done is
// low, which enforces the four-phase handshake.
module snap_host_side #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic ack_async,
    output logic req_out,
    output logic done
);
    snap_sync #(.STAGES(SYNC_N)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_async),
        .q     (done)
    );

    // Start a request only from an idle handshake; keep it while held.
    always_ff @(posedge clk) begin
        if (!rst_n) req_out <= 1'b0;
        else        req_out <= hold_req & (req_out | ~done);
    end
endmodule

// File: rtl/snap_read_port.sv
// Module: host read port over the frozen snapshot.
// Splits the snapshot into bus-wide words and returns the addressed one.
// Purely combinational: reads change no state.
// Assumes the snapshot is stable while the host reads it (done high).
module snap_read_port #(
    parameter int CNT_W  = 32,
    parameter int BUS_W  = 16,
    parameter int WORDS  = 2,
    parameter int ADDR_W = 1
) (
    input  logic [CNT_W-1:0]  snapshot,
    input  logic [ADDR_W-1:0] addr,
    output logic [BUS_W-1:0]  data
);
    localparam int PAD_W = WORDS * BUS_W;

    logic [PAD_W-1:0] padded;
    logic [BUS_W-1:0] words [WORDS];

    assign padded = PAD_W'(snapshot);

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign words[w] = padded[w*BUS_W +: BUS_W];
    end

    // Select the addressed word; unused addresses read zero.
    always_comb begin
        data = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (addr == ADDR_W'(i)) data = words[i];
        end
    end
endmodule

// File: rtl/snap_timer_reader.sv
// Module: snapshot-latched wide timer reader (top).
// A timer-domain counter is captured into a snapshot through a
// synchronized four-phase hold handshake. The host reads the snapshot in
// bus-wide halves. The two clocks are treated as unrelated.
module snap_timer_reader
    import snap_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int BUS_W  = DEF_BUS_W,
    parameter int SYNC_N = DEF_SYNC_N,
    localparam int WORDS  = word_count(CNT_W, BUS_W),
    localparam int ADDR_W = addr_width(WORDS)
) (
    input  logic              tmr_clk,
    input  logic              tmr_rst_n,
    input  logic              host_clk,
    input  logic              host_rst_n,
    input  logic              hold_req,
    output logic              cap_done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BUS_W-1:0]  rd_data
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] snap_q;
    logic             cap_p;
    logic             ack_q;
    logic             req_q;

    snap_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (tmr_clk),
        .rst_n (tmr_rst_n),
        .count (cnt_q)
    );

    snap_capture #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_capture (
        .clk       (tmr_clk),
        .rst_n     (tmr_rst_n),
        .req_async (req_q),
        .count     (cnt_q),
        .cap_fire  (cap_p),
        .ack       (ack_q),
        .snapshot  (snap_q)
    );

    snap_host_side #(.SYNC_N(SYNC_N)) u_host (
        .clk       (host_clk),
        .rst_n     (host_rst_n),
        .hold_req  (hold_req),
        .ack_async (ack_q),
        .req_out   (req_q),
        .done      (cap_done)
    );

    snap_read_port #(
        .CNT_W (CNT_W),
        .BUS_W (BUS_W),
        .WORDS (WORDS),
        .ADDR_W(ADDR_W)
    ) u_read (
        .snapshot (snap_q),
        .addr     (rd_addr),
        .data     (rd_data)
    );
endmodule

// File: rtl/snap_timer_reader_chk.sv
// Module: assertion checker for snap_timer_reader, attached by bind.
// Watches the counter, capture, snapshot and handshake across both domains.
module snap_timer_reader_chk #(
    parameter int CNT_W = 32
) (
    input logic             tmr_clk,
    input logic             tmr_rst_n,
    input logic             host_clk,
    input logic             host_rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] snap,
    input logic             cap,
    input logic             req_h,
    input logic             done
);
    // R1: one count per timer clock, modular wrap.
    a_r1_count_step: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        $past(tmr_rst_n) |-> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

    // R4: the snapshot holds the full count seen on the capture cycle.
    a_r4_capture_value: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        cap |=> (snap == CNT_W'(cnt - CNT_W'(1))));

    // R5: snapshot frozen whenever no capture fired.
    a_r5_snap_frozen: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        !cap |=> $stable(snap));

    // R7: a capture lasts one timer cycle.
    a_r7_single_capture: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        cap |=> !cap);

    // R7: the forwarded request only rises when the done flag was low.
    a_r7_req_waits_idle: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        $rose(req_h) |-> !$past(done));
endmodule

bind snap_timer_reader snap_timer_reader_chk #(.CNT_W(CNT_W)) u_chk (
    .tmr_clk    (tmr_clk),
    .tmr_rst_n  (tmr_rst_n),
    .host_clk   (host_clk),
    .host_rst_n (host_rst_n),
    .cnt        (cnt_q),
    .snap       (snap_q),
    .cap        (cap_p),
    .req_h      (req_q),
    .done       (cap_done)
);

// File: tb/snap_timer_reader_bench.sv
`timescale 1ns/100ps
// Bench: 12-bit counter, 6-bit bus, 125 MHz host clock, 11 ns timer clock.
module snap_timer_reader_bench;
    localparam int CW   = 12;
    localparam int BW   = 6;
    localparam logic [CW-1:0] MASK = '1;

    logic          tmr_clk = 1'b0;
    logic          host_clk = 1'b0;
    logic          tmr_rst_n = 1'b0;
    logic          host_rst_n = 1'b0;
    logic          hold_req = 1'b0;
    logic          cap_done;
    logic [0:0]    rd_addr = 1'b0;
    logic [BW-1:0] rd_data;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    logic [CW-1:0] model = '0;

    snap_timer_reader #(.CNT_W(CW), .BUS_W(BW), .SYNC_N(2)) u_snap_timer_reader (
        .tmr_clk    (tmr_clk),
        .tmr_rst_n  (tmr_rst_n),
        .host_clk   (host_clk),
        .host_rst_n (host_rst_n),
        .hold_req   (hold_req),
        .cap_done   (cap_done),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    always #4 host_clk = ~host_clk;
    initial begin
        #0.2;
        forever #5.5 tmr_clk = ~tmr_clk;
    end

    // Bench tick model: one count per timer edge out of reset.
    always @(posedge tmr_clk) begin
        if (!tmr_rst_n) model <= '0;
        else            model <= model + 1'b1;
    end

    initial begin
        repeat (5) @(negedge tmr_clk);
        tmr_rst_n = 1'b1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic read_snap(output logic [CW-1:0] v);
        logic [BW-1:0] lo, hi;
        @(negedge host_clk);
        rd_addr = 1'b0;
        #1 lo = rd_data;
        rd_addr = 1'b1;
        #1 hi = rd_data;
        v = {hi, lo};
    endtask

    task automatic wait_done(input logic lvl);
        while (cap_done !== lvl) @(negedge host_clk);
    endtask

    // Full capture: request, poll done, read, check window, release.
    task automatic capture(input int gap, input string tag, output logic [CW-1:0] v);
        logic [CW-1:0] lo_t, hi_t, d_s, d_h;
        repeat (gap) @(negedge host_clk);
        @(negedge host_clk);
        hold_req = 1'b1;
        lo_t = model;
        wait_done(1'b1);
        hi_t = model;
        read_snap(v);
        d_s = (v - lo_t) & MASK;
        d_h = (hi_t - lo_t) & MASK;
        check(d_s >= 2 && d_s <= d_h, tag, int'(v), int'(lo_t) + 2);
        hold_req = 1'b0;
        wait_done(1'b0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] s0, s1, s2, prev;
        logic [BW-1:0] w;
        int wraps;
        bit saw_low;

        repeat (8) @(negedge host_clk);
        // R2: reset state
        check(cap_done === 1'b0, "R2 done low in reset", int'(cap_done), 0);
        host_rst_n = 1'b1;
        repeat (3) @(negedge host_clk);
        rd_addr = 1'b0;
        #1 check(rd_data === '0, "R2 low half zero", int'(rd_data), 0);
        rd_addr = 1'b1;
        #1 check(rd_data === '0, "R2 high half zero", int'(rd_data), 0);
        check(cap_done === 1'b0, "R2 done low after reset", int'(cap_done), 0);

        // R3 / R4 / R8: single capture inside the window
        capture(3, "R3 R4 R8 single capture window", s0);

        // R5 / R8: frozen and side-effect free under repeated reads
        repeat (60) @(negedge host_clk);
        for (int k = 0; k < 10; k++) begin
            rd_addr = k[0];
            #1 w = rd_data;
            check(w == (k[0] ? s0[CW-1:BW] : s0[BW-1:0]), "R8 repeated read", int'(w),
                  int'(k[0] ? s0[CW-1:BW] : s0[BW-1:0]));
            @(negedge host_clk);
        end
        read_snap(s1);
        check(s1 == s0, "R5 snapshot frozen", int'(s1), int'(s0));

        // R6 / R7: a held request captures once
        @(negedge host_clk);
        hold_req = 1'b1;
        wait_done(1'b1);
        read_snap(s1);
        repeat (300) @(negedge host_clk);
        check(cap_done === 1'b1, "R6 done stays while held", int'(cap_done), 1);
        read_snap(s2);
        check(s2 == s1, "R7 no recapture while held", int'(s2), int'(s1));

        // R7 / R6: dip and re-raise while done high is deferred
        hold_req = 1'b0;
        @(negedge host_clk);
        hold_req = 1'b1;
        saw_low = 0;
        while (cap_done !== 1'b0) @(negedge host_clk);
        saw_low = 1;
        check(saw_low, "R6 done falls after drop", int'(cap_done), 0);
        wait_done(1'b1);
        read_snap(s2);
        check(s2 != s1, "R7 deferred request captures anew", int'(s2), int'(s1) + 1);
        hold_req = 1'b0;
        wait_done(1'b0);

        // R1 / R3 / R4: sweep of phases across several wraps
        wraps = 0;
        capture(0, "R3 sweep start", prev);
        for (int i = 0; i < 800; i++) begin
            capture(i % 5, "R1 R4 sweep window", s0);
            if (s0 < prev) wraps++;
            prev = s0;
        end
        check(wraps >= 1, "R1 counter wrapped to zero", wraps, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule